// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block keeps the 8-bit routing field of every interrupt line in a multiprocessor interrupt distributor. Software reaches it through a simple register access port. Each request carries the requester's CPU number, an interrupt ID, a write flag and a size flag that selects a single byte or a 32-bit word. Only the shared lines (ID 32 and up) have storage. The 32 low lines are private to each processor. Their fields are never stored: a read returns a value made from the requesting CPU's number, and a write to them does nothing.

A parameter selects how a field is encoded. In mask mode (`TGT_ONEHOT=1`) the field is a CPU bit mask, so CPU c is bit c. In number mode (`TGT_ONEHOT=0`) the field holds the CPU number itself. The field encoding also controls the injection path. When a shared peripheral line fires, its field selects one CPU, and the block sets that CPU's pending bit for the line. An illegal injection raises a one-cycle error flag instead. An injection is illegal if it uses a private line, uses a line past the last one, or (in mask mode) names more than one CPU.

Top module: `irqtgt_bank`

## Requirements
- R1: While reset is asserted and straight after it, `pend_o`, `err_o` and `acc_rvalid` are 0, and every stored field reads as 0.
- R2: A byte read of an ID in 0..31 returns the requester's own field in bits 7:0 and zero above. The field is `1 << acc_cpu` in mask mode and `acc_cpu` in number mode.
- R3: A word read whose aligned group lies in 0..31 returns the requester's field in all four bytes.
- R4: A byte write (`acc_word=0`) to an ID in 32..NUM_IRQS-1 stores `acc_wdata[7:0]` in that line's field and changes no other field.
- R5: A word access clears the two low ID bits to form a base. Byte k of the word (bits 8k+7:8k) is the field of line base+k, for both reads and writes.
- R6: Writes to IDs 0..31 are ignored. This includes the lanes of a word write that fall in that range.
- R7: An ID at or above NUM_IRQS reads as 0, and a write to it changes nothing.
- R8: `acc_rvalid` is high in the cycle after every read request, with `acc_rdata` valid in that cycle. A write or an idle cycle leaves `acc_rvalid` low in the following cycle.
- R9: A legal injection sets bit `cpu*(NUM_IRQS-32) + (id-32)` of `pend_o` in the next cycle. The CPU is c when field bit c is set (mask mode), or c when the field equals c (number mode). The injection uses the field value from before any write in the same cycle.
- R10: An injection with an ID below 32 or at or above NUM_IRQS pulses `err_o` for one cycle in the next cycle and leaves `pend_o` unchanged.
- R11: In mask mode, a field with two or more bits set makes an injection raise `err_o` and set no pending bit. A field that names no existing CPU sets no pending bit and raises no error. Such a field is a zero mask, a single bit at or above NUM_CPUS, or a number at or above NUM_CPUS.
- R12: Pending bits stay set until reset. The block never clears them, and without an injection `pend_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| acc_cpu | input | CPU_W | Number of the requesting CPU |
| acc_id | input | ID_W | Interrupt ID addressed |
| acc_wdata | input | 32 | Write data |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read |
| acc_rdata | output | 32 | Read data |
| inj_valid | input | 1 | Peripheral interrupt injection strobe |
| inj_id | input | ID_W | ID of the injected line |
| pend_o | output | NUM_CPUS*(NUM_IRQS-32) | Pending bits, grouped by CPU |
| err_o | output | 1 | Illegal injection flag, one cycle |

## Verification
A corrupted stored field is not visible until it is read or used for injection. A read shows it in `acc_rdata` one cycle after the request. An injection shows it in the same cycle as the read path would, as a pending bit in the wrong CPU's group or as a false error. A fault in lane alignment shows as a byte moved within a word read. A fault in the private-line decode shows as a stored value, or a CPU that is not the requester, in the low range. Stuck or lost pending bits appear in `pend_o` one cycle after the injection that should have set them.

// File: rtl/irqtgt_pkg.sv
package irqtgt_pkg;
  localparam int BANKED_LINES = 32;
  localparam int FIELD_W      = 8;

  // Field value a private line shows to the CPU that reads it
  function automatic logic [FIELD_W-1:0] banked_field(input logic onehot,
                                                      input logic [2:0] cpu);
    if (onehot) return 8'd1 << cpu;
    else        return {5'b0, cpu};
  endfunction
endpackage

// File: rtl/irqtgt_store.sv
module irqtgt_store import irqtgt_pkg::*; #(
  parameter int NUM_IRQS = 64,
  parameter int ID_W     = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic                                      wr_word,
  input  logic [ID_W-1:0]                           wr_id,
  input  logic [31:0]                               wr_data,
  output logic [(NUM_IRQS-BANKED_LINES)*FIELD_W-1:0] fields_o
);
  localparam int SHARED = NUM_IRQS - BANKED_LINES;

  for (genvar i = 0; i < SHARED; i++) begin : g_line
    localparam logic [ID_W-1:0] LINE_ID = ID_W'(i + BANKED_LINES);
    logic               hit;
    logic               line_en;
    logic [FIELD_W-1:0] wbyte;
    logic [FIELD_W-1:0] field_d;
    logic [FIELD_W-1:0] field_q;

    always_comb begin
      hit     = wr_word ? (wr_id[ID_W-1:2] == LINE_ID[ID_W-1:2]) : (wr_id == LINE_ID);
      wbyte   = wr_word ? wr_data[8*(i%4) +: 8] : wr_data[7:0];
      line_en = wr_en && hit;
      field_d = line_en ? wbyte : field_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       field_q <= '0;
      else if (line_en) field_q <= field_d;
    end

    assign fields_o[i*FIELD_W +: FIELD_W] = field_q;
  end
endmodule

// File: rtl/irqtgt_field_sel.sv
module irqtgt_field_sel import irqtgt_pkg::*; #(
  parameter int NUM_IRQS   = 64,
  parameter int ID_W       = 8,
  parameter int CPU_W      = 2,
  parameter int TGT_ONEHOT = 1
) (
  input  logic [CPU_W-1:0]                          cpu,
  input  logic [ID_W-1:0]                           id,
  input  logic [(NUM_IRQS-BANKED_LINES)*FIELD_W-1:0] fields,
  output logic [FIELD_W-1:0]                        field
);
  logic [31:0] idv;
  assign idv = 32'(id);

  always_comb begin
    field = '0;
    if (idv < 32'(BANKED_LINES))
      field = banked_field(TGT_ONEHOT != 0, 3'(cpu));
    else if (idv < 32'(NUM_IRQS))
      field = fields[(idv - 32'(BANKED_LINES))*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/irqtgt_inject.sv
module irqtgt_inject import irqtgt_pkg::*; #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_IRQS   = 64,
  parameter int ID_W       = 8,
  parameter int TGT_ONEHOT = 1
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       inj_valid,
  input  logic [ID_W-1:0]                            inj_id,
  input  logic [FIELD_W-1:0]                         tgt,
  output logic [NUM_CPUS*(NUM_IRQS-BANKED_LINES)-1:0] pend_o,
  output logic                                       err_o
);
  localparam int SHARED = NUM_IRQS - BANKED_LINES;
  localparam int PW     = NUM_CPUS * SHARED;

  logic [31:0]       idv;
  logic              in_range;
  logic              multi;
  logic              legal;
  logic [SHARED-1:0] line_hot;
  logic [NUM_CPUS-1:0] cpu_hot;
  logic [PW-1:0]     pend_d, pend_q;
  logic              err_d, err_q;

  assign idv = 32'(inj_id);

  always_comb begin
    in_range = (idv >= 32'(BANKED_LINES)) && (idv < 32'(NUM_IRQS));
    multi    = (TGT_ONEHOT != 0) && ($countones(tgt) > 1);
    legal    = inj_valid && in_range && !multi;
    err_d    = inj_valid && !(in_range && !multi);
    for (int l = 0; l < SHARED; l++)
      line_hot[l] = legal && (idv == 32'(l + BANKED_LINES));
    for (int c = 0; c < NUM_CPUS; c++)
      cpu_hot[c] = (TGT_ONEHOT != 0) ? tgt[c] : (tgt == FIELD_W'(c));
    for (int c = 0; c < NUM_CPUS; c++)
      for (int l = 0; l < SHARED; l++)
        pend_d[c*SHARED + l] = pend_q[c*SHARED + l] | (cpu_hot[c] & line_hot[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (inj_valid) pend_q <= pend_d;
      err_q <= err_d;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;
endmodule

// File: rtl/irqtgt_bank.sv
module irqtgt_bank import irqtgt_pkg::*; #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_IRQS   = 64,
  parameter int ID_W       = 8,
  parameter int CPU_W      = 2,
  parameter int TGT_ONEHOT = 1
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       acc_valid,
  input  logic                                       acc_write,
  input  logic                                       acc_word,
  input  logic [CPU_W-1:0]                           acc_cpu,
  input  logic [ID_W-1:0]                            acc_id,
  input  logic [31:0]                                acc_wdata,
  output logic                                       acc_rvalid,
  output logic [31:0]                                acc_rdata,
  input  logic                                       inj_valid,
  input  logic [ID_W-1:0]                            inj_id,
  output logic [NUM_CPUS*(NUM_IRQS-BANKED_LINES)-1:0] pend_o,
  output logic                                       err_o
);
  localparam int SHARED = NUM_IRQS - BANKED_LINES;
  localparam int LANES  = 32 / FIELD_W;

  logic [SHARED*FIELD_W-1:0] fields;
  logic [FIELD_W-1:0]        lane_field [LANES];
  logic [FIELD_W-1:0]        inj_tgt;
  logic                      wr_fire, rd_fire;
  logic [31:0]               rdata_d, rdata_q;
  logic                      rvalid_q;

  assign wr_fire = acc_valid && acc_write;
  assign rd_fire = acc_valid && !acc_write;

  irqtgt_store #(.NUM_IRQS(NUM_IRQS), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_word(acc_word),
    .wr_id(acc_id), .wr_data(acc_wdata), .fields_o(fields));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ID_W-1:0] lane_id;
    assign lane_id = acc_word ? {acc_id[ID_W-1:2], 2'(k)} : acc_id;
    irqtgt_field_sel #(.NUM_IRQS(NUM_IRQS), .ID_W(ID_W), .CPU_W(CPU_W),
                       .TGT_ONEHOT(TGT_ONEHOT)) u_sel (
      .cpu(acc_cpu), .id(lane_id), .fields(fields), .field(lane_field[k]));
  end

  irqtgt_field_sel #(.NUM_IRQS(NUM_IRQS), .ID_W(ID_W), .CPU_W(CPU_W),
                     .TGT_ONEHOT(TGT_ONEHOT)) u_inj_sel (
    .cpu('0), .id(inj_id), .fields(fields), .field(inj_tgt));

  irqtgt_inject #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .ID_W(ID_W),
                  .TGT_ONEHOT(TGT_ONEHOT)) u_inject (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_id(inj_id),
    .tgt(inj_tgt), .pend_o(pend_o), .err_o(err_o));

  always_comb begin
    if (acc_word)
      rdata_d = {lane_field[3], lane_field[2], lane_field[1], lane_field[0]};
    else
      rdata_d = {24'b0, lane_field[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (rd_fire) rdata_q <= rdata_d;
      rvalid_q <= rd_fire;
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rvalid = rvalid_q;
endmodule

// File: rtl/irqtgt_bank_chk.sv
module irqtgt_bank_chk #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_IRQS   = 64,
  parameter int ID_W       = 8,
  parameter int CPU_W      = 2,
  parameter int TGT_ONEHOT = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             acc_valid,
  input logic                             acc_write,
  input logic                             acc_word,
  input logic [CPU_W-1:0]                 acc_cpu,
  input logic [ID_W-1:0]                  acc_id,
  input logic                             acc_rvalid,
  input logic [31:0]                      acc_rdata,
  input logic                             inj_valid,
  input logic [ID_W-1:0]                  inj_id,
  input logic [NUM_CPUS*(NUM_IRQS-32)-1:0] pend_o,
  input logic                             err_o
);
  logic rd_req, low_acc, high_acc, low_inj, bad_inj;
  assign rd_req   = acc_valid && !acc_write;
  assign low_acc  = 32'(acc_id) < 32;
  assign high_acc = 32'(acc_id) >= 32'(NUM_IRQS);
  assign low_inj  = 32'(inj_id) < 32;
  assign bad_inj  = low_inj || (32'(inj_id) >= 32'(NUM_IRQS));

  a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> acc_rvalid);
  a_r8_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !acc_rvalid);
  a_r2_banked_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_word && low_acc) |=>
      (acc_rdata[31:8] == 24'd0) &&
      ((TGT_ONEHOT != 0) ? (acc_rdata[7:0] == (8'd1 << $past(acc_cpu)))
                         : (acc_rdata[7:0] == 8'($past(acc_cpu)))));
  a_r3_banked_word_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_word && low_acc) |=>
      (acc_rdata[31:24] == acc_rdata[7:0]) && (acc_rdata[23:16] == acc_rdata[7:0]) &&
      (acc_rdata[15:8] == acc_rdata[7:0]));
  a_r7_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_word && high_acc) |=> (acc_rdata == 32'd0));
  a_r10_err_on_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && bad_inj) |=> (err_o && $stable(pend_o)));
  a_r10_err_needs_inject: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |=> !err_o);
  a_r12_pend_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |=> $stable(pend_o));
  a_r12_pend_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
  a_r9_single_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> ($countones(pend_o ^ $past(pend_o)) <= 1));
endmodule

bind irqtgt_bank irqtgt_bank_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .ID_W(ID_W), .CPU_W(CPU_W),
  .TGT_ONEHOT(TGT_ONEHOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_id(acc_id),
  .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .inj_valid(inj_valid),
  .inj_id(inj_id), .pend_o(pend_o), .err_o(err_o));

// File: tb/irqtgt_bank_tb.sv
`timescale 1ns/1ps
module irqtgt_bank_tb;
  localparam int NC = 4, NI = 64, IW = 8, CW = 2;
  localparam int SH = NI - 32;
  localparam int PW = NC * SH;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          acc_valid, acc_write, acc_word;
  logic [CW-1:0] acc_cpu;
  logic [IW-1:0] acc_id, inj_id;
  logic [31:0]   acc_wdata;
  logic          inj_valid;
  logic          rv1, rv0, err1, err0;
  logic [31:0]   rd1, rd0;
  logic [PW-1:0] pend1, pend0;

  irqtgt_bank #(.NUM_CPUS(NC), .NUM_IRQS(NI), .ID_W(IW), .CPU_W(CW), .TGT_ONEHOT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_id(acc_id), .acc_wdata(acc_wdata),
    .acc_rvalid(rv1), .acc_rdata(rd1), .inj_valid(inj_valid), .inj_id(inj_id),
    .pend_o(pend1), .err_o(err1));

  irqtgt_bank #(.NUM_CPUS(NC), .NUM_IRQS(NI), .ID_W(IW), .CPU_W(CW), .TGT_ONEHOT(0)) u_dut_id (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_id(acc_id), .acc_wdata(acc_wdata),
    .acc_rvalid(rv0), .acc_rdata(rd0), .inj_valid(inj_valid), .inj_id(inj_id),
    .pend_o(pend0), .err_o(err0));

  int n_cmp = 0, n_bad = 0;
  logic [7:0]    tgt_m [SH];
  logic [PW-1:0] pm1, pm0;

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_field(bit mode, int cpu, int id);
    if (id < 32)  return mode ? (8'd1 << cpu) : 8'(cpu);
    if (id < NI)  return tgt_m[id-32];
    return 8'd0;
  endfunction

  function automatic logic [31:0] exp_read(bit mode, bit word, int cpu, int id);
    int b;
    if (!word) return {24'b0, exp_field(mode, cpu, id)};
    b = id & ~3;
    return {exp_field(mode, cpu, b+3), exp_field(mode, cpu, b+2),
            exp_field(mode, cpu, b+1), exp_field(mode, cpu, b)};
  endfunction

  task automatic model_inj(bit mode, int id, inout logic [PW-1:0] pm, output bit err);
    logic [7:0] t;
    err = 1'b0;
    if (id < 32 || id >= NI) begin err = 1'b1; return; end
    t = tgt_m[id-32];
    if (mode) begin
      if ($countones(t) > 1) begin err = 1'b1; return; end
      for (int c = 0; c < NC; c++) if (t[c]) pm[c*SH + id-32] = 1'b1;
    end else if (int'(t) < NC) pm[int'(t)*SH + id-32] = 1'b1;
  endtask

  task automatic access(bit wr, bit word, int cpu, int id, logic [31:0] d, string tag);
    logic [31:0] e1, e0;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_word = word;
    acc_cpu = CW'(cpu); acc_id = IW'(id); acc_wdata = d;
    e1 = exp_read(1, word, cpu, id);
    e0 = exp_read(0, word, cpu, id);
    @(negedge clk);
    acc_valid = 1'b0;
    if (wr) begin
      if (word) begin
        for (int k = 0; k < 4; k++) begin
          int l = (id & ~3) + k;
          if (l >= 32 && l < NI) tgt_m[l-32] = d[8*k +: 8];
        end
      end else if (id >= 32 && id < NI) tgt_m[id-32] = d[7:0];
      chk({tag, " R8 no rvalid after write"}, PW'(rv1), '0);
    end else begin
      chk({tag, " R8 rvalid mask"}, PW'(rv1), PW'(1));
      chk({tag, " mask-mode rdata"}, PW'(rd1), PW'(e1));
      chk({tag, " number-mode rdata"}, PW'(rd0), PW'(e0));
    end
  endtask

  task automatic inject(int id, string tag);
    bit e1, e0;
    @(negedge clk);
    inj_valid = 1'b1; inj_id = IW'(id);
    model_inj(1, id, pm1, e1);
    model_inj(0, id, pm0, e0);
    @(negedge clk);
    inj_valid = 1'b0;
    chk({tag, " mask pend"}, pend1, pm1);
    chk({tag, " mask err"}, PW'(err1), PW'(e1));
    chk({tag, " number pend"}, pend0, pm0);
    chk({tag, " number err"}, PW'(err0), PW'(e0));
  endtask

  function automatic logic [7:0] rand_byte();
    case ($urandom % 4)
      0: return 8'd1 << ($urandom % 6);
      1: return 8'($urandom % 6);
      2: return 8'($urandom);
      default: return 8'd0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < SH; i++) tgt_m[i] = 8'd0;
    pm1 = '0; pm0 = '0;
    rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_word = 0; acc_cpu = '0;
    acc_id = '0; acc_wdata = '0; inj_valid = 0; inj_id = '0;
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", pend1, '0);
    chk("R1 err/rvalid in reset", PW'({err1, rv1, err0, rv0}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pend after reset", pend0, '0);
    access(0, 1, 0, 40, 0, "R1 stored word reads zero");

    access(0, 0, 2, 5, 0, "R2 banked byte cpu2");
    access(0, 1, 3, 13, 0, "R3 banked word cpu3");
    access(0, 1, 1, 30, 0, "R3 banked word cpu1");
    access(1, 0, 0, 33, 32'hFFFF_FFA5, "R4 byte write 33");
    access(0, 0, 1, 33, 0, "R4 byte readback 33");
    access(0, 1, 2, 34, 0, "R4 neighbours untouched");
    access(1, 1, 0, 46, 32'h4433_2211, "R5 word write base 44");
    access(0, 0, 0, 44, 0, "R5 lane0 -> 44");
    access(0, 0, 0, 47, 0, "R5 lane3 -> 47");
    access(0, 1, 3, 45, 0, "R5 word read packing");
    access(1, 0, 1, 10, 32'h0000_00FF, "R6 write to private line");
    access(0, 0, 1, 10, 0, "R6 private line unchanged");
    access(1, 1, 2, 30, 32'hFFFF_FFFF, "R6 word write on private group");
    access(0, 1, 2, 32, 0, "R6 shared group unchanged");
    access(1, 0, 0, 70, 32'h0000_0077, "R7 write beyond range");
    access(0, 0, 0, 70, 0, "R7 read beyond range");
    access(0, 1, 0, 66, 0, "R7 word read beyond range");

    access(1, 0, 0, 40, 32'h04, "R9 set field 40");
    inject(40, "R9 inject 40");
    access(1, 0, 0, 41, 32'h03, "R11 set field 41");
    inject(41, "R11 multi-bit / number 3");
    access(1, 0, 0, 42, 32'h00, "R11 zero field");
    inject(42, "R11 zero field inject");
    access(1, 0, 0, 43, 32'h20, "R11 high bit field");
    inject(43, "R11 no such cpu");
    inject(5, "R10 private line inject");
    inject(64, "R10 beyond range inject");
    inject(40, "R12 repeat inject holds");
    access(1, 0, 0, 40, 32'h01, "R12 retarget 40");
    inject(40, "R12 old bit kept");

    for (int n = 0; n < 1500; n++) begin
      int op = $urandom % 3;
      int id = $urandom % 72;
      int cpu = $urandom % NC;
      if (op == 0) begin
        logic [31:0] d = {rand_byte(), rand_byte(), rand_byte(), rand_byte()};
        access(1, $urandom % 2, cpu, id, d, "R4/R5 random write");
      end else if (op == 1) begin
        access(0, $urandom % 2, cpu, id, 0, "R2/R3/R5/R7 random read");
      end else begin
        inject(($urandom % 4 == 0) ? id : 32 + ($urandom % SH), "R9/R10/R11 random inject");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule